// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block holds the configuration of a small set of hardware debug triggers for a 32-bit hart. Each trigger has three registers: a control word, a compare value and a context-qualifier word. A select register picks the trigger that the shared access port reaches. A read-only capability register reports which trigger kinds exist, and a machine context register holds the value that context qualifiers are compared against. The access port is a plain one-cycle register port. A write lands on the next clock edge. Read data is combinational from the address. The port has no back-pressure: every access completes in the cycle it is presented.

Each write to a control or qualifier word is legalized before it is stored. Fields that are not implemented are forced to zero, and encodings that are not supported are replaced by legal ones. The stored value is therefore a cleaned copy of what software wrote. Every trigger's stored words go out on flat buses to the match logic. A per-trigger one-cycle strobe tells that logic when a trigger's control or compare word has actually changed.

Top module: `dtrig_bank`

## Requirements
- R1: After reset the select register is 0, the context register is 0, every control word reads 0x2000_0000 (kind 2, all other bits zero), and every compare and qualifier word reads 0.
- R2: A write of value v to the select register (address code 0) takes effect only when v < NUM_TRIG. Otherwise the previous selection is kept.
- R3: The stored control word always has bits 31:28 equal to 2 and bit 27 (debugger-only flag) equal to 0, whatever was written.
- R4: A control write (address code 1) keeps only the privilege enables (bits 3, 4 and 6) and the load, store and execute enables (bits 0, 1 and 2). All other bits outside the size field are stored as zero, including the match, chain, action, timing, select and hit fields.
- R5: The size code is formed as {bits 22:21, bits 17:16}. It is kept only for the values 0, 1, 2, 3 and 5, meaning any, 1, 2, 4 and 8 bytes. Any other code stores both parts as zero.
- R6: A qualifier write (address code 3) keeps bits 31:26 and bit 25. Bits 24:23 are cleared, so the 3-bit selector in bits 25:23 becomes 0 for codes 0 to 3 and 4 for codes 4 to 7. Bits 22:0 are stored as zero.
- R7: The capability register (address code 4) reads 0x0000_0044, and writes to it have no effect.
- R8: Reads of address codes 1, 2 and 3 return the words of the selected trigger, and writes to them change only that trigger. The select register reads back at code 0.
- R9: In the cycle after a control or compare write that changes the stored word, the strobe bit of the selected trigger is high for one cycle. A write that leaves the stored word unchanged, or a qualifier write, raises no strobe.
- R10: The compare word (code 2) is stored exactly as written, and the context register (code 5) reads back the full value written. Codes 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 3 | Register code: 0 select, 1 control, 2 compare, 3 qualifier, 4 capability, 5 context |
| csr_we | input | 1 | Write enable for the addressed register |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Combinational read data for csr_addr |
| trig_ctl | output | 32*NUM_TRIG | Stored control words, trigger i at bits 32*i+31:32*i |
| trig_cmp | output | 32*NUM_TRIG | Stored compare words |
| trig_ext | output | 32*NUM_TRIG | Stored qualifier words |
| mctx | output | 32 | Machine context register |
| trig_reconf | output | NUM_TRIG | Per-trigger one-cycle reconfigure strobe |

## Verification
The bench builds the block with NUM_TRIG = 2 and WIDE_SIZE = 1. Two triggers are enough to write one trigger and confirm that the other, unselected one stays untouched. They also make a select value of 2 the first out-of-range value, so the range check is exercised at its boundary. With WIDE_SIZE set, the upper size bits take part, and the codes 4, 5 and 15 can be driven: one legal and two illegal (4 and 15).

// File: rtl/dtrig_pkg.sv
package dtrig_pkg;
  typedef enum logic [2:0] {
    CSR_SEL  = 3'd0,
    CSR_CTL  = 3'd1,
    CSR_CMP  = 3'd2,
    CSR_EXT  = 3'd3,
    CSR_INFO = 3'd4,
    CSR_CTX  = 3'd5
  } csr_code_e;

  localparam logic [3:0]  KIND_ADDR_MATCH = 4'd2;
  localparam logic [31:0] CTL_KIND_BITS   = {KIND_ADDR_MATCH, 28'h0};
  // privilege enables (3,4,6) and access enables (0,1,2)
  localparam logic [31:0] CTL_KEEP_MASK   = 32'h0000_005F;
  localparam logic [31:0] SIZE_LO_MASK    = 32'h0003_0000;
  localparam logic [31:0] SIZE_HI_MASK    = 32'h0060_0000;
  // context value (31:26) plus top bit of the selector (25)
  localparam logic [31:0] EXT_KEEP_MASK   = 32'hFE00_0000;
  localparam logic [31:0] INFO_VALUE      = 32'h0000_0044;

  function automatic logic size_code_ok(input logic [3:0] code);
    return (code <= 4'd3) || (code == 4'd5);
  endfunction
endpackage

// File: rtl/dtrig_ctl_legal.sv
module dtrig_ctl_legal
  import dtrig_pkg::*;
#(
  parameter bit WIDE_SIZE = 1'b1
) (
  input  logic [31:0] raw,
  output logic [31:0] legal
);
  logic [3:0]  size_code;
  logic [31:0] size_mask;

  generate
    if (WIDE_SIZE) begin : g_wide
      assign size_code = {raw[22:21], raw[17:16]};
      assign size_mask = SIZE_HI_MASK | SIZE_LO_MASK;
    end else begin : g_narrow
      assign size_code = {2'b00, raw[17:16]};
      assign size_mask = SIZE_LO_MASK;
    end
  endgenerate

  always_comb begin
    legal = CTL_KIND_BITS | (raw & CTL_KEEP_MASK);
    if (size_code_ok(size_code)) legal = legal | (raw & size_mask);
  end
endmodule

// File: rtl/dtrig_ext_legal.sv
module dtrig_ext_legal
  import dtrig_pkg::*;
(
  input  logic [31:0] raw,
  output logic [31:0] legal
);
  // selector codes 0..3 collapse to 0, 4..7 to 4: only bit 25 survives
  assign legal = raw & EXT_KEEP_MASK;
endmodule

// File: rtl/dtrig_slot.sv
module dtrig_slot
  import dtrig_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctl,
  input  logic        wr_cmp,
  input  logic        wr_ext,
  input  logic [31:0] ctl_new,
  input  logic [31:0] cmp_new,
  input  logic [31:0] ext_new,
  output logic [31:0] ctl,
  output logic [31:0] cmp,
  output logic [31:0] ext,
  output logic        reconf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= CTL_KIND_BITS;
      cmp    <= '0;
      ext    <= '0;
      reconf <= 1'b0;
    end else begin
      if (wr_ctl) ctl <= ctl_new;
      if (wr_cmp) cmp <= cmp_new;
      if (wr_ext) ext <= ext_new;
      reconf <= (wr_ctl && (ctl_new != ctl)) || (wr_cmp && (cmp_new != cmp));
    end
  end

  p_kind_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[31:28] == KIND_ADDR_MATCH) && !ctl[27]);
  p_size_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    size_code_ok({ctl[22:21], ctl[17:16]}));
  p_ext_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext[24:0] == 25'd0);
  p_change_strobes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl != $past(ctl)) || (cmp != $past(cmp))) |-> reconf);
  p_strobe_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reconf |-> ($past(wr_ctl) || $past(wr_cmp)));
endmodule

// File: rtl/dtrig_bank.sv
module dtrig_bank
  import dtrig_pkg::*;
#(
  parameter int NUM_TRIG  = 2,
  parameter bit WIDE_SIZE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             csr_addr,
  input  logic                   csr_we,
  input  logic [31:0]            csr_wdata,
  output logic [31:0]            csr_rdata,
  output logic [32*NUM_TRIG-1:0] trig_ctl,
  output logic [32*NUM_TRIG-1:0] trig_cmp,
  output logic [32*NUM_TRIG-1:0] trig_ext,
  output logic [31:0]            mctx,
  output logic [NUM_TRIG-1:0]    trig_reconf
);
  localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic [SEL_W-1:0] sel_q;
  logic [31:0]      ctx_q;
  logic [31:0]      ctl_legal, ext_legal;
  logic [31:0]      ctl_a [NUM_TRIG];
  logic [31:0]      cmp_a [NUM_TRIG];
  logic [31:0]      ext_a [NUM_TRIG];
  logic             sel_wr, sel_in_range;

  dtrig_ctl_legal #(.WIDE_SIZE(WIDE_SIZE)) u_ctl_legal (
    .raw(csr_wdata), .legal(ctl_legal));
  dtrig_ext_legal u_ext_legal (.raw(csr_wdata), .legal(ext_legal));

  assign sel_wr       = csr_we && (csr_addr == CSR_SEL);
  assign sel_in_range = csr_wdata < 32'(NUM_TRIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      ctx_q <= '0;
    end else begin
      if (sel_wr && sel_in_range) sel_q <= csr_wdata[SEL_W-1:0];
      if (csr_we && (csr_addr == CSR_CTX)) ctx_q <= csr_wdata;
    end
  end

  generate
    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_slot
      logic hit;
      assign hit = csr_we && (sel_q == SEL_W'(i));
      dtrig_slot u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctl (hit && (csr_addr == CSR_CTL)),
        .wr_cmp (hit && (csr_addr == CSR_CMP)),
        .wr_ext (hit && (csr_addr == CSR_EXT)),
        .ctl_new(ctl_legal),
        .cmp_new(csr_wdata),
        .ext_new(ext_legal),
        .ctl    (ctl_a[i]),
        .cmp    (cmp_a[i]),
        .ext    (ext_a[i]),
        .reconf (trig_reconf[i])
      );
      assign trig_ctl[32*i +: 32] = ctl_a[i];
      assign trig_cmp[32*i +: 32] = cmp_a[i];
      assign trig_ext[32*i +: 32] = ext_a[i];
    end
  endgenerate

  assign mctx = ctx_q;

  always_comb begin
    unique case (csr_addr)
      CSR_SEL:  csr_rdata = 32'(sel_q);
      CSR_CTL:  csr_rdata = ctl_a[sel_q];
      CSR_CMP:  csr_rdata = cmp_a[sel_q];
      CSR_EXT:  csr_rdata = ext_a[sel_q];
      CSR_INFO: csr_rdata = INFO_VALUE;
      CSR_CTX:  csr_rdata = ctx_q;
      default:  csr_rdata = '0;
    endcase
  end

  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !sel_in_range) |=> $stable(sel_q));
  p_info_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == CSR_INFO) |-> (csr_rdata == 32'h0000_0044));
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig_reconf));
endmodule

// File: tb/dtrig_bank_bench.sv
module dtrig_bank_bench;
  localparam int NT = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      csr_addr = 3'd0;
  logic            csr_we = 1'b0;
  logic [31:0]     csr_wdata = '0;
  logic [31:0]     csr_rdata;
  logic [32*NT-1:0] trig_ctl, trig_cmp, trig_ext;
  logic [31:0]     mctx;
  logic [NT-1:0]   trig_reconf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    int          kind;  // 0 rdata, 1 strobe, 2 ctl slice, 3 cmp slice, 4 mctx
    int          idx;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  dtrig_bank #(.NUM_TRIG(NT), .WIDE_SIZE(1'b1)) u_dtrig_bank (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .trig_ctl(trig_ctl),
    .trig_cmp(trig_cmp), .trig_ext(trig_ext), .mctx(mctx),
    .trig_reconf(trig_reconf));

  // monitor: pops every expectation queued for this cycle
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = csr_rdata;
        1:       act = 32'(trig_reconf);
        2:       act = trig_ctl[32*it.idx +: 32];
        3:       act = trig_cmp[32*it.idx +: 32];
        default: act = mctx;
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                 it.req, it.kind, it.idx, act, it.exp);
      end
    end
  end

  task automatic expect_item(input int kind, input int idx,
                             input logic [31:0] exp, input string req);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(posedge clk); #1;
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    csr_addr = a;
    expect_item(0, 0, exp, req);
    @(posedge clk); #1;
  endtask

  task automatic strobe(input logic [31:0] exp, input string req);
    expect_item(1, 0, exp, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(3'd0, 32'h0, "R1");
    rd(3'd1, 32'h2000_0000, "R1");
    rd(3'd2, 32'h0, "R1");
    rd(3'd3, 32'h0, "R1");
    rd(3'd5, 32'h0, "R1");
    expect_item(2, 1, 32'h2000_0000, "R1");

    // R3 R4 R5: all ones -> size code 15 illegal
    wr(3'd1, 32'hFFFF_FFFF); strobe(32'h1, "R9");
    rd(3'd1, 32'h2000_005F, "R3");
    // size 5 legal, kind/debug flag/hit/action dropped
    wr(3'd1, 32'h1831_1045); strobe(32'h1, "R9");
    rd(3'd1, 32'h2021_0045, "R5");
    // size 3
    wr(3'd1, 32'h0003_004C);
    rd(3'd1, 32'h2003_004C, "R4");
    // size 4 illegal: both parts cleared
    wr(3'd1, 32'h0020_0001);
    rd(3'd1, 32'h2000_0001, "R5");
    // same legalized value again: no strobe
    wr(3'd1, 32'h0020_0001); strobe(32'h0, "R9");
    expect_item(2, 0, 32'h2000_0001, "R4");

    // R10 compare
    wr(3'd2, 32'h8000_1234); strobe(32'h1, "R9");
    rd(3'd2, 32'h8000_1234, "R10");
    wr(3'd2, 32'h8000_1234); strobe(32'h0, "R9");

    // R6 qualifier
    wr(3'd3, 32'hFFFF_FFFF); strobe(32'h0, "R9");
    rd(3'd3, 32'hFE00_0000, "R6");
    wr(3'd3, 32'h0380_0000);
    rd(3'd3, 32'h0200_0000, "R6");
    wr(3'd3, 32'h0180_0000);
    rd(3'd3, 32'h0000_0000, "R6");

    // R8 select trigger 1
    wr(3'd0, 32'd1);
    rd(3'd0, 32'd1, "R8");
    rd(3'd1, 32'h2000_0000, "R8");
    wr(3'd2, 32'h0000_A5A5); strobe(32'h2, "R9");
    rd(3'd2, 32'h0000_A5A5, "R8");
    expect_item(3, 0, 32'h8000_1234, "R8");
    expect_item(3, 1, 32'h0000_A5A5, "R8");

    // R2 out-of-range select ignored
    wr(3'd0, 32'd2);
    rd(3'd0, 32'd1, "R2");
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 32'd1, "R2");
    wr(3'd0, 32'd0);
    rd(3'd2, 32'h8000_1234, "R2");

    // R7 capability
    rd(3'd4, 32'h0000_0044, "R7");
    wr(3'd4, 32'h0);
    rd(3'd4, 32'h0000_0044, "R7");

    // R10 context and unused codes
    wr(3'd5, 32'h1234_5678);
    rd(3'd5, 32'h1234_5678, "R10");
    expect_item(4, 0, 32'h1234_5678, "R10");
    rd(3'd6, 32'h0, "R10");
    rd(3'd7, 32'h0, "R10");

    @(posedge clk); #1;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule